// File: doc/BRIEF.md
# Decode-Stage Hazard and Redirect Controller

This block decides, every cycle, whether the front of a five-stage in-order integer pipeline may advance. It looks at the instruction currently in decode, at what the execute and memory stages are about to write back, and at whether the instruction and data memories can accept work. From these it drives the program-counter enable, the fetch/decode register enable, a flush that turns the fetch/decode register into a no-op, and a bubble that zeroes the control signals leaving decode.

Conditional branches and register-indirect jumps are resolved in decode. They compare operands taken straight from the register file and do not use forwarded values. Such an instruction must therefore wait until any older instruction that writes one of its source registers has reached write-back. That wait is one or two cycles. A load followed at once by a consumer needs a one-cycle wait. Fetch predicts not-taken, so a taken branch or any jump discards the one instruction fetched behind it. The block itself holds no state. Its outputs depend only on its inputs in the same cycle. The clock and reset are used only to sample its behaviour over time.

Top module: `hazard_ctrl`

## Requirements
- R1: When the execute-stage instruction is a load that writes a nonzero destination equal to either decode source register, the block stalls (load-use hazard).
- R2: Every stall drives `pc_en` and `ifid_en` low and `bubble` high. Whenever there is no stall, `pc_en` and `ifid_en` are high and `bubble` is low.
- R3: A decode-stage conditional branch or register-indirect jump stalls when the execute-stage instruction writes the register file with a nonzero destination equal to either source register.
- R4: The same branch/indirect-jump stall applies when the memory-stage instruction writes the register file with a matching nonzero destination.
- R5: A destination of register 0 never causes a stall, whatever the stage or instruction kind.
- R6: `flush` is high when a conditional branch is taken (`dec_branch` and `dec_br_taken`), or on any direct jump (`dec_jal`) or register-indirect jump (`dec_jalr`).
- R7: A conditional branch that is not taken and has no hazard costs no cycle: enables high, `flush` and `bubble` low.
- R8: When `imem_ready` or `dmem_ready` is low, the block stalls.
- R9: A stall takes priority over a flush: `flush` is never high in a cycle in which `pc_en` is low.
- R10: With no hazard, no redirect and both memories ready, the enables are high and `flush` and `bubble` are low.
- R11: A non-load, non-branch decode instruction does not stall because of a register-writing producer in execute or memory, since forwarding covers it.
- R12: `dec_br_taken` has no effect unless `dec_branch` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the block's behaviour |
| rst_n | input | 1 | Synchronous active-low reset for the sampling logic |
| dec_rs1 | input | REG_AW | First source register of the decode instruction |
| dec_rs2 | input | REG_AW | Second source register of the decode instruction |
| dec_branch | input | 1 | Decode instruction is a conditional branch |
| dec_br_taken | input | 1 | Branch comparison in decode is true |
| dec_jal | input | 1 | Decode instruction is a direct jump |
| dec_jalr | input | 1 | Decode instruction is a register-indirect jump |
| ex_rd | input | REG_AW | Destination register of the execute-stage instruction |
| ex_rf_we | input | 1 | Execute-stage instruction writes the register file |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_rf_we | input | 1 | Memory-stage instruction writes the register file |
| imem_ready | input | 1 | Instruction memory can deliver this cycle |
| dmem_ready | input | 1 | Data memory has finished its access |
| pc_en | output | 1 | Program counter may update |
| ifid_en | output | 1 | Fetch/decode register may load |
| flush | output | 1 | Replace the fetch/decode register contents with a no-op |
| bubble | output | 1 | Zero the decode-stage control signals |

## Verification
The assertions check on every cycle that the stall outputs stay consistent with each other, that a flush never coincides with a stall, and that a memory that is not ready always freezes the front end. They also check that load-use and branch-operand matches on live destinations always stall, and that register 0 alone never stalls. Only the bench's scenarios can show the cases where a hazard is absent: an ALU producer does not hold up an ordinary instruction, a not-taken branch costs nothing, and the taken flag is ignored without a branch. The bench's reference model is compared across a random sweep of register overlaps and ready patterns.

// File: rtl/hzd_pkg.sv
// Package: shared constants for the hazard controller.
// Assumes later stages are indexed youngest first (execute, then memory).
package hzd_pkg;
    localparam int unsigned STG_EX  = 0;
    localparam int unsigned STG_MEM = 1;
    localparam int unsigned N_LATE  = 2;

    // Output bundle of the controller, one bit per front-end control.
    typedef struct packed {
        logic pc_en;
        logic ifid_en;
        logic flush;
        logic bubble;
    } hzd_ctl_t;
endpackage

// File: rtl/hzd_dst_match.sv
// Module: compares one later-stage destination against both decode sources.
// Assumes register 0 is hardwired to zero, so it never produces a hit.
module hzd_dst_match #(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] rs1,
    input  logic [REG_AW-1:0] rs2,
    input  logic [REG_AW-1:0] dst,
    input  logic              wr_en,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Purpose: flag a live write to a register the decode instruction reads.
    always_comb begin
        hit = wr_en && (dst != ZERO_REG) && ((dst == rs1) || (dst == rs2));
    end
endmodule

// File: rtl/hzd_redirect.sv
// Module: decides whether fetch must be redirected and gates it by stall.
// Assumes fetch predicts not-taken, so only taken control flow discards.
module hzd_redirect (
    input  logic branch,
    input  logic br_taken,
    input  logic jal,
    input  logic jalr,
    input  logic stall,
    output logic flush
);
    logic redirect;

    // Purpose: any change of flow away from the sequential path.
    always_comb begin
        redirect = (branch && br_taken) || jal || jalr;
    end

    // Purpose: a stalled decode instruction has not resolved yet, so no flush.
    always_comb begin
        flush = redirect && !stall;
    end
endmodule

// File: rtl/hazard_ctrl.sv
// Module: top of the decode-stage hazard and redirect controller.
// Assumes branch and register-indirect jump operands come from the register
// file unforwarded, and that other operands are forwarded in execute.
// Purely combinational; clk and rst_n feed the bound checker only.
module hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic              dec_branch,
    input  logic              dec_br_taken,
    input  logic              dec_jal,
    input  logic              dec_jalr,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_rf_we,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_rf_we,
    input  logic              imem_ready,
    input  logic              dmem_ready,
    output logic              pc_en,
    output logic              ifid_en,
    output logic              flush,
    output logic              bubble
);
    logic [REG_AW-1:0] late_rd [N_LATE];
    logic [N_LATE-1:0] late_we;
    logic [N_LATE-1:0] late_hit;
    logic              load_use;
    logic              operand_wait;
    logic              mem_wait;
    logic              stall;
    logic              flush_w;
    hzd_ctl_t          ctl;

    // Purpose: gather later-stage writeback info into indexed arrays.
    always_comb begin
        late_rd[STG_EX]  = ex_rd;
        late_rd[STG_MEM] = mem_rd;
        late_we[STG_EX]  = ex_rf_we;
        late_we[STG_MEM] = mem_rf_we;
    end

    // One destination comparator per later stage.
    for (genvar s = 0; s < N_LATE; s++) begin : g_match
        hzd_dst_match #(.REG_AW(REG_AW)) u_match (
            .rs1   (dec_rs1),
            .rs2   (dec_rs2),
            .dst   (late_rd[s]),
            .wr_en (late_we[s]),
            .hit   (late_hit[s])
        );
    end

    // Purpose: classify the three stall causes.
    always_comb begin
        load_use     = ex_is_load && late_hit[STG_EX];
        operand_wait = (dec_branch || dec_jalr) && (|late_hit);
        mem_wait     = !imem_ready || !dmem_ready;
        stall        = load_use || operand_wait || mem_wait;
    end

    hzd_redirect u_redirect (
        .branch   (dec_branch),
        .br_taken (dec_br_taken),
        .jal      (dec_jal),
        .jalr     (dec_jalr),
        .stall    (stall),
        .flush    (flush_w)
    );

    // Purpose: build the control bundle and drive the outputs.
    always_comb begin
        ctl.pc_en   = !stall;
        ctl.ifid_en = !stall;
        ctl.bubble  = stall;
        ctl.flush   = flush_w;
        pc_en       = ctl.pc_en;
        ifid_en     = ctl.ifid_en;
        flush       = ctl.flush;
        bubble      = ctl.bubble;
    end
endmodule

// File: rtl/hazard_ctrl_chk.sv
// Module: assertion checker for hazard_ctrl, attached by bind.
// Assumes it sees the same ports as the controller; samples at clock edges.
module hazard_ctrl_chk #(
    parameter int unsigned REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] dec_rs1,
    input logic [REG_AW-1:0] dec_rs2,
    input logic              dec_branch,
    input logic              dec_br_taken,
    input logic              dec_jal,
    input logic              dec_jalr,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_rf_we,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_rf_we,
    input logic              imem_ready,
    input logic              dmem_ready,
    input logic              pc_en,
    input logic              ifid_en,
    input logic              flush,
    input logic              bubble
);
    assert_stall_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en == ifid_en) && (bubble == !pc_en));

    assert_load_use_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_rf_we && ex_rd != '0 && (ex_rd == dec_rs1 || ex_rd == dec_rs2))
        |-> !pc_en);

    assert_branch_ex_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_branch || dec_jalr) && ex_rf_we && ex_rd != '0
         && (ex_rd == dec_rs1 || ex_rd == dec_rs2)) |-> bubble);

    assert_branch_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_branch || dec_jalr) && mem_rf_we && mem_rd != '0
         && (mem_rd == dec_rs1 || mem_rd == dec_rs2)) |-> bubble);

    assert_zero_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0 && mem_rd == '0 && imem_ready && dmem_ready) |-> pc_en);

    assert_mem_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!imem_ready || !dmem_ready) |-> (!pc_en && !ifid_en));

    assert_stall_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> pc_en);

    assert_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en && (dec_jal || dec_jalr || (dec_branch && dec_br_taken))) |-> flush);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_hazard_ctrl_chk (.*);

// File: tb/test_hazard_ctrl.sv
// Bench: behavioural reference model compared against hazard_ctrl each cycle.
module test_hazard_ctrl;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] dec_rs1 = '0, dec_rs2 = '0, ex_rd = '0, mem_rd = '0;
    logic          dec_branch = 0, dec_br_taken = 0, dec_jal = 0, dec_jalr = 0;
    logic          ex_rf_we = 0, ex_is_load = 0, mem_rf_we = 0;
    logic          imem_ready = 1, dmem_ready = 1;
    logic          pc_en, ifid_en, flush, bubble;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    hazard_ctrl #(.REG_AW(AW)) i_hazard_ctrl (.*);

    // Reference: returns {pc_en, ifid_en, flush, bubble} from the requirements.
    function automatic logic [3:0] ref_model();
        bit lu, bw, mw, st, rd;
        bit ex_live, mem_live;
        ex_live  = ex_rf_we && int'(ex_rd) != 0 &&
                   (ex_rd == dec_rs1 || ex_rd == dec_rs2);
        mem_live = mem_rf_we && int'(mem_rd) != 0 &&
                   (mem_rd == dec_rs1 || mem_rd == dec_rs2);
        lu = ex_is_load && ex_live;
        bw = (dec_branch || dec_jalr) && (ex_live || mem_live);
        mw = !(imem_ready && dmem_ready);
        st = lu || bw || mw;
        rd = (dec_branch && dec_br_taken) || dec_jal || dec_jalr;
        return {!st, !st, rd && !st, st};
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {pc_en, ifid_en, flush, bubble};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {pc_en,ifid_en,flush,bubble} got %b expected %b",
                     tag, act, exp);
        end
    endtask

    task automatic idle();
        dec_rs1 = 0; dec_rs2 = 0; ex_rd = 0; mem_rd = 0;
        dec_branch = 0; dec_br_taken = 0; dec_jal = 0; dec_jalr = 0;
        ex_rf_we = 0; ex_is_load = 0; mem_rf_we = 0;
        imem_ready = 1; dmem_ready = 1;
    endtask

    // Inputs settle 1 ns after a rising edge, outputs sampled 2 ns later.
    task automatic step(input string tag, input logic [3:0] exp);
        #2;
        check(tag, exp);
        check({tag, " model"}, ref_model());
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: run did not end, got timeout expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        @(posedge clk); #1;
        step("R10 reset idle", 4'b1100);
        @(posedge clk); @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        step("R10 idle", 4'b1100);

        idle(); ex_is_load = 1; ex_rf_we = 1; ex_rd = 5; dec_rs1 = 5;
        step("R1 load-use rs1", 4'b0001);
        idle(); ex_is_load = 1; ex_rf_we = 1; ex_rd = 7; dec_rs2 = 7; dec_rs1 = 3;
        step("R1 load-use rs2 R2", 4'b0001);

        idle(); ex_rf_we = 1; ex_rd = 5; dec_rs1 = 5; mem_rf_we = 1; mem_rd = 5;
        step("R11 alu producer no stall", 4'b1100);

        idle(); dec_branch = 1; dec_br_taken = 1; ex_rf_we = 1; ex_rd = 5; dec_rs1 = 5;
        step("R3 branch ex producer R9", 4'b0001);
        idle(); dec_jalr = 1; ex_rf_we = 1; ex_rd = 9; dec_rs1 = 9;
        step("R3 jalr ex producer R9", 4'b0001);

        idle(); dec_branch = 1; mem_rf_we = 1; mem_rd = 6; dec_rs2 = 6; dec_rs1 = 1;
        step("R4 branch mem producer", 4'b0001);
        idle(); dec_branch = 1; dec_br_taken = 1; mem_rf_we = 1; mem_rd = 4;
        dec_rs1 = 2; dec_rs2 = 3;
        step("R4 mem producer mismatch R6", 4'b1110);

        idle(); dec_branch = 1; dec_br_taken = 1; ex_rf_we = 1; ex_is_load = 1;
        mem_rf_we = 1;
        step("R5 x0 destinations", 4'b1110);
        idle(); ex_is_load = 1; ex_rf_we = 1;
        step("R5 x0 load", 4'b1100);

        idle(); dec_branch = 1; dec_br_taken = 1; dec_rs1 = 8;
        step("R6 taken branch", 4'b1110);
        idle(); dec_jal = 1; ex_rf_we = 1; ex_rd = 3; dec_rs1 = 3;
        step("R6 jal", 4'b1110);
        idle(); dec_jalr = 1; dec_rs1 = 12;
        step("R6 jalr", 4'b1110);

        idle(); dec_branch = 1; dec_rs1 = 1; dec_rs2 = 2;
        step("R7 not-taken branch", 4'b1100);

        idle(); dec_br_taken = 1;
        step("R12 taken flag without branch", 4'b1100);

        idle(); imem_ready = 0;
        step("R8 imem wait", 4'b0001);
        idle(); dmem_ready = 0; dec_jal = 1;
        step("R8 dmem wait R9", 4'b0001);

        for (int i = 0; i < 3000; i++) begin
            dec_rs1      = AW'($urandom_range(0, 3));
            dec_rs2      = AW'($urandom_range(0, 3));
            ex_rd        = AW'($urandom_range(0, 3));
            mem_rd       = AW'($urandom_range(0, 3));
            dec_branch   = 1'($urandom_range(0, 1));
            dec_br_taken = 1'($urandom_range(0, 1));
            dec_jal      = ($urandom_range(0, 5) == 0);
            dec_jalr     = ($urandom_range(0, 5) == 0);
            ex_rf_we     = 1'($urandom_range(0, 1));
            ex_is_load   = 1'($urandom_range(0, 1));
            mem_rf_we    = 1'($urandom_range(0, 1));
            imem_ready   = ($urandom_range(0, 7) != 0);
            dmem_ready   = ($urandom_range(0, 7) != 0);
            #2;
            check("R2 random sweep", ref_model());
            @(posedge clk);
            #1;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule